// File: doc/BRIEF.md
# UART Receive Queue with Idle Timeout

This block is the holding buffer between a serial deserializer and the software-facing side of a UART receiver. Each byte that the deserializer presents is written into a circular store of `DEPTH` entries. The block keeps only a write pointer and an occupancy count. The oldest entry's position is computed from those two values, so no separate read pointer exists.

Two gate inputs control intake. The enable must be high and the disable must be low before any write or read takes effect, and the disable wins when both are set. A write that arrives while the store is full is discarded and produces an overflow pulse. A flush request empties the store.

An idle timer measures the gap after each accepted byte. The gap is four character times, counted in baud ticks. When the gap ends, a timeout pulse is produced, but only while the timeout setting is nonzero.

Top module: `uart_rx_queue`

## Requirements
- R1: A write or read takes effect only when `rx_on` is 1 and `rx_off` is 0. `rx_off` = 1 blocks both, whatever the value of `rx_on`. A blocked write or read leaves `level` and `rd_byte` unchanged.
- R2: An accepted write stores `wr_byte` at the write pointer and advances that pointer modulo `DEPTH`. `level` rises by one on the next clock edge and never exceeds `DEPTH`.
- R3: A write that arrives while `level` equals `DEPTH` (judged on the count before that edge) is dropped. The stored contents stay as they were, and `ovf_pulse` is 1 for exactly the one cycle after that edge.
- R4: An accepted read of a non-empty store loads `rd_byte`, on the next edge, with the entry at index (DEPTH + write pointer − level) mod DEPTH. That entry is the oldest byte still held, so bytes come out in arrival order across pointer wrap. `level` drops by one.
- R5: An accepted read of an empty store sets `rd_byte` to 0 and leaves `level` unchanged.
- R6: A read and a write accepted on the same edge both act on the pre-edge state. The read returns the old oldest byte, the write is kept unless the store was full, and `level` changes by (write kept) − (read of non-empty).
- R7: `flush` = 1 clears the write pointer and `level` on the next edge. It overrides any write or read presented in the same cycle: that write is not stored, no overflow pulse is produced, and `rd_byte` holds its value.
- R8: Each accepted byte reloads the idle timer with 4 × `char_ticks` baud ticks. The timer counts `baud_tick` strobes, and `tmo_pulse` is 1 for the one cycle after the edge that consumes the last tick. A byte accepted before expiry restarts the full span.
- R9: When the span expires, `tmo_pulse` is produced only if `tmo_cfg` is nonzero. After one expiry the timer stays quiet until the next accepted byte.
- R10: After reset, `level`, `rd_byte`, `ovf_pulse` and `tmo_pulse` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_on | input | 1 | Receiver enable |
| rx_off | input | 1 | Receiver disable, overrides `rx_on` |
| flush | input | 1 | Receiver reset request: empties the store |
| wr_valid | input | 1 | A byte is offered by the deserializer this cycle |
| wr_byte | input | 8 | Byte offered by the deserializer |
| rd_req | input | 1 | Read the oldest byte |
| baud_tick | input | 1 | One-cycle baud tick strobe |
| char_ticks | input | TICK_W | Length of one character, in baud ticks |
| tmo_cfg | input | 8 | Timeout setting; zero suppresses the timeout pulse |
| rd_byte | output | 8 | Data returned by the most recent accepted read |
| level | output | $clog2(DEPTH+1) | Number of bytes held |
| ovf_pulse | output | 1 | One-cycle pulse for a dropped write |
| tmo_pulse | output | 1 | One-cycle pulse when the idle span expires |

## Verification
The hardest state to reach from the ports is the idle timer's expiry boundary. The bench must show that the pulse appears on exactly the tick that ends the span and never earlier. It must also show that a byte arriving mid-span restarts the whole count. The stimulus drives single baud ticks one at a time after a write and samples `tmo_pulse` after every tick. A second byte is inserted partway through the span, and the pulse is expected only after a fresh full span. The same walk is repeated with `tmo_cfg` at zero and after an expiry, to show that no pulse appears in those cases. A full store wrapped around the pointer boundary is reached by filling the store, forcing an overflow, and then draining it, with concurrent read/write cycles mixed in.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // advance a ring index by one, wrapping at depth
  function automatic int ring_next(input int idx, input int depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction

  // oldest held entry: derived from write index and occupancy
  function automatic int ring_head(input int wr_idx, input int held, input int depth);
    return (depth + wr_idx - held) % depth;
  endfunction

  // idle span in baud ticks: four character times
  function automatic int idle_span(input int char_len);
    return char_len * 4;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_go,
  input  logic [7:0]    wr_byte,
  input  logic          rd_go,
  output logic [7:0]    rd_byte,
  output logic [CW-1:0] level,
  output logic          wr_taken,
  output logic          ovf_pulse
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wp;
  logic [CW-1:0] cnt;
  logic [PW-1:0] head;
  logic          full, empty, rd_taken, ovf_evt;

  assign full     = (cnt == CW'(DEPTH));
  assign empty    = (cnt == '0);
  assign head     = PW'(rxq_pkg::ring_head(int'(wp), int'(cnt), DEPTH));
  assign wr_taken = wr_go & ~full & ~flush;
  assign rd_taken = rd_go & ~empty & ~flush;
  assign ovf_evt  = wr_go & full & ~flush;

  always_ff @(posedge clk) begin
    if (wr_taken) mem[wp] <= wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp        <= '0;
      cnt       <= '0;
      rd_byte   <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= ovf_evt;
      if (flush) begin
        wp  <= '0;
        cnt <= '0;
      end else begin
        if (wr_taken) wp <= PW'(rxq_pkg::ring_next(int'(wp), DEPTH));
        cnt <= cnt + CW'(wr_taken) - CW'(rd_taken);
        if (rd_go) rd_byte <= empty ? 8'h00 : mem[head];
      end
    end
  end

  assign level = cnt;

  // R3
  ovf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> ($past(level) == CW'(DEPTH)) && $past(wr_go));

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0) && !ovf_pulse);

  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !flush && !wr_go && level == '0) |=> (rd_byte == 8'h00) && (level == '0));

endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int TICK_W = 12,
  parameter int TW     = TICK_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              tick,
  input  logic [TICK_W-1:0] char_ticks,
  input  logic              cfg_nz,
  output logic              fire
);
  logic [TW-1:0] remain;
  logic          armed;
  logic [TW-1:0] span;

  assign span = TW'(rxq_pkg::idle_span(int'(char_ticks)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      armed  <= 1'b0;
      fire   <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (restart) begin
        remain <= span;
        armed  <= 1'b1;
      end else if (armed && tick) begin
        if (remain <= TW'(1)) begin
          armed <= 1'b0;
          fire  <= cfg_nz;
        end else begin
          remain <= remain - TW'(1);
        end
      end
    end
  end

  // R9
  tmo_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(cfg_nz) && $past(armed) && $past(tick));

  // R8
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !fire && armed);

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int DEPTH  = 8,
  parameter int TICK_W = 12,
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_on,
  input  logic              rx_off,
  input  logic              flush,
  input  logic              wr_valid,
  input  logic [7:0]        wr_byte,
  input  logic              rd_req,
  input  logic              baud_tick,
  input  logic [TICK_W-1:0] char_ticks,
  input  logic [7:0]        tmo_cfg,
  output logic [7:0]        rd_byte,
  output logic [CW-1:0]     level,
  output logic              ovf_pulse,
  output logic              tmo_pulse
);
  logic take_en, wr_go, rd_go, wr_taken;

  assign take_en = rx_on & ~rx_off;
  assign wr_go   = wr_valid & take_en;
  assign rd_go   = rd_req & take_en;

  rxq_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_go(wr_go), .wr_byte(wr_byte), .rd_go(rd_go),
    .rd_byte(rd_byte), .level(level),
    .wr_taken(wr_taken), .ovf_pulse(ovf_pulse)
  );

  rxq_idle_timer #(.TICK_W(TICK_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(wr_taken), .tick(baud_tick),
    .char_ticks(char_ticks), .cfg_nz(tmo_cfg != 8'h00), .fire(tmo_pulse)
  );

  // R1
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_en && !flush) |=> $stable(level) && $stable(rd_byte) && !ovf_pulse);

  // R1
  off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_off && wr_valid) |-> !wr_taken);

endmodule

// File: tb/test_uart_rx_queue.sv
module test_uart_rx_queue;
  localparam int D  = 8;
  localparam int TW = 12;
  localparam int CW = $clog2(D + 1);

  logic clk = 0, rst_n = 0;
  logic rx_on = 0, rx_off = 0, flush = 0, wr_valid = 0, rd_req = 0, baud_tick = 0;
  logic [7:0] wr_byte = 0, tmo_cfg = 0;
  logic [TW-1:0] char_ticks = 0;
  logic [7:0] rd_byte;
  logic [CW-1:0] level;
  logic ovf_pulse, tmo_pulse;

  int runs = 0, fails = 0;
  logic [7:0] sb[$];
  logic [7:0] last_rd = 0;

  always #10 clk = ~clk;

  uart_rx_queue #(.DEPTH(D), .TICK_W(TW)) i_uart_rx_queue (
    .clk(clk), .rst_n(rst_n), .rx_on(rx_on), .rx_off(rx_off), .flush(flush),
    .wr_valid(wr_valid), .wr_byte(wr_byte), .rd_req(rd_req), .baud_tick(baud_tick),
    .char_ticks(char_ticks), .tmo_cfg(tmo_cfg), .rd_byte(rd_byte), .level(level),
    .ovf_pulse(ovf_pulse), .tmo_pulse(tmo_pulse)
  );

  function automatic bit gate();
    return rx_on && !rx_off;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: offer one byte, model decides acceptance
  task automatic put(input logic [7:0] b, input string req);
    bit ov;
    ov = gate() && sb.size() == D;
    if (gate() && !ov) sb.push_back(b);
    wr_valid = 1; wr_byte = b;
    @(negedge clk);
    wr_valid = 0;
    chk(ovf_pulse == ov, req, ovf_pulse, ov);
    chk(int'(level) == sb.size(), req, level, sb.size());
  endtask

  // monitor side: read and compare against the scoreboard
  task automatic get(input string req);
    logic [7:0] e;
    if (!gate()) e = last_rd;
    else if (sb.size() > 0) e = sb.pop_front();
    else e = 8'h00;
    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
    last_rd = e;
    chk(rd_byte == e, req, rd_byte, e);
    chk(int'(level) == sb.size(), req, level, sb.size());
  endtask

  task automatic both(input logic [7:0] b, input string req);
    int pre;
    logic [7:0] e;
    pre = sb.size();
    e = (pre > 0) ? sb[0] : 8'h00;
    if (pre < D) sb.push_back(b);
    if (pre > 0) void'(sb.pop_front());
    wr_valid = 1; wr_byte = b; rd_req = 1;
    @(negedge clk);
    wr_valid = 0; rd_req = 0;
    last_rd = e;
    chk(rd_byte == e, req, rd_byte, e);
    chk(ovf_pulse == (pre == D), req, ovf_pulse, pre == D);
    chk(int'(level) == sb.size(), req, level, sb.size());
  endtask

  task automatic tick_once(input bit exp, input string req);
    baud_tick = 1;
    @(negedge clk);
    baud_tick = 0;
    chk(tmo_pulse == exp, req, tmo_pulse, exp);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10
    chk(level == 0, "R10", level, 0);
    chk(rd_byte == 0, "R10", rd_byte, 0);
    chk(!ovf_pulse && !tmo_pulse, "R10", {ovf_pulse, tmo_pulse}, 0);
    rst_n = 1;
    @(negedge clk);
    rx_on = 1;

    // R2 / R4: basic traffic
    put(8'h11, "R2"); put(8'h22, "R2"); put(8'h33, "R2");
    get("R4"); get("R4"); get("R4");
    // R5
    get("R5");

    // R3: fill, overflow, drain across pointer wrap (R4)
    for (int i = 0; i < D; i++) put(8'hA0 + 8'(i), "R2");
    put(8'hEE, "R3");
    @(negedge clk);
    chk(!ovf_pulse, "R3", ovf_pulse, 0);
    for (int i = 0; i < D; i++) get("R4");
    get("R5");

    // R1: gating
    put(8'h5A, "R2"); put(8'h6B, "R2");
    rx_off = 1;
    put(8'h77, "R1"); get("R1");
    rx_on = 0;
    put(8'h78, "R1"); get("R1");
    rx_off = 0;
    put(8'h79, "R1"); get("R1");
    rx_on = 1;

    // R6: concurrent read and write (non-empty, empty, full)
    both(8'hC1, "R6"); both(8'hC2, "R6");
    get("R4"); get("R4"); get("R5");
    both(8'hD0, "R6");
    for (int i = 0; i < D - 1; i++) put(8'h40 + 8'(i), "R2");
    both(8'hF0, "R6");
    for (int i = 0; i < D; i++) get("R4");

    // R7: flush overrides a same-cycle write and read
    put(8'h99, "R2");
    flush = 1; wr_valid = 1; wr_byte = 8'h55; rd_req = 1;
    @(negedge clk);
    flush = 0; wr_valid = 0; rd_req = 0;
    sb.delete();
    chk(level == 0, "R7", level, 0);
    chk(!ovf_pulse, "R7", ovf_pulse, 0);
    chk(rd_byte == last_rd, "R7", rd_byte, last_rd);
    get("R7");

    // R8: idle span of 4*2 = 8 ticks
    char_ticks = 2; tmo_cfg = 8'h05;
    put(8'h01, "R2");
    for (int i = 0; i < 7; i++) tick_once(0, "R8");
    tick_once(1, "R8");
    @(negedge clk);
    chk(!tmo_pulse, "R8", tmo_pulse, 0);
    // R9: no repeat after expiry
    for (int i = 0; i < 10; i++) tick_once(0, "R9");
    // R8: restart mid-span
    put(8'h02, "R2");
    for (int i = 0; i < 5; i++) tick_once(0, "R8");
    put(8'h03, "R8");
    for (int i = 0; i < 7; i++) tick_once(0, "R8");
    tick_once(1, "R8");
    // R9: zero setting suppresses the pulse
    tmo_cfg = 8'h00;
    put(8'h04, "R2");
    for (int i = 0; i < 9; i++) tick_once(0, "R9");

    summary();
    $finish;
  end
endmodule